// File: doc/BRIEF.md
# Process-Tagged Translation Buffer with Access Rights

This block translates virtual addresses into physical addresses for 4 KiB pages. It holds a small set of mappings. Each mapping records a virtual page number, the process it belongs to, a physical frame number and three rights bits (read, write, execute). Every lookup compares its page number and process identifier against all stored mappings in parallel. The low 12 address bits pass straight through to the physical address. Because each mapping carries a process identifier, mappings from several address spaces can stay resident side by side. A context switch therefore only needs a flush when tagging is not in use.

The response comes one cycle after the lookup. It is exactly one of three outcomes: a hit carrying the physical address, a miss, or a rights fault. After a miss, software writes the absent mapping through the fill port. The fill port picks its slot in this order: an existing slot with the same page and process, then the lowest empty slot, then a round-robin pointer. A flush clears every mapping in one cycle.

Top module: `xlat_buffer`

## Requirements
- R1: A lookup asserted in cycle N produces its response in cycle N+1 with `rsp_valid` high. On a hit, `rsp_paddr` equals the stored frame number joined above the lookup's low 12 address bits, and those bits are unchanged.
- R2: A hit requires three things of one stored mapping: it is valid, its page number equals `lk_vaddr[31:12]`, and its process identifier equals `lk_pid`. The same page under a different process identifier is not a hit.
- R3: A lookup that matches no stored mapping reports `rsp_miss`, with `rsp_paddr` zero.
- R4: `lk_kind` is encoded 00 read, 01 write, 10 execute, 11 reserved. `fill_perm` bit 0 grants read, bit 1 grants write and bit 2 grants execute. A matching lookup whose kind is not granted reports `rsp_fault` with `rsp_paddr` zero. Kind 11 always faults on a match. A miss takes precedence over a fault.
- R5: `flush` invalidates all mappings in the cycle it is asserted. A lookup in that same cycle reports a miss, and later lookups miss until the mappings are refilled.
- R6: Each response asserts exactly one of `rsp_hit`, `rsp_miss`, `rsp_fault`. In a cycle after no lookup, `rsp_valid` and all three flags are low.
- R7: A fill whose page number and process identifier are already present overwrites that slot's frame and rights. No second slot is taken.
- R8: A fill that does not overwrite takes the lowest-numbered empty slot. When no slot is empty, it replaces the slot named by a pointer. The pointer starts at 0 after reset and steps by one (wrapping after 16 slots) each time it is used.
- R9: A lookup in the same cycle as a fill sees the contents from before the fill. The fill is visible from the next cycle on. When `fill_valid` and `flush` coincide, the flush wins and the fill is dropped.
- R10: With process 3's page 0x14 mapped to frame 0x2 and read granted, a read of virtual address 0x14303 returns physical address 0x2303.
- R11: After reset, all response outputs are zero and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_pid | input | 8 | Process identifier of the lookup |
| lk_kind | input | 2 | Access kind (00 read, 01 write, 10 execute, 11 reserved) |
| fill_valid | input | 1 | Write a mapping this cycle |
| fill_vpn | input | 20 | Page number of the mapping |
| fill_pid | input | 8 | Process identifier of the mapping |
| fill_pfn | input | 20 | Frame number of the mapping |
| fill_perm | input | 3 | Rights: bit 0 read, bit 1 write, bit 2 execute |
| flush | input | 1 | Invalidate every mapping |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No matching mapping |
| rsp_fault | output | 1 | Mapping found but access kind not granted |
| rsp_paddr | output | 32 | Physical address on a hit, zero otherwise |

## Verification
The single-match property depends on fills being the only way mappings enter the buffer. It assumes no pair of page number and process identifier is ever stored twice, which the overwrite rule guarantees as long as fills are applied one per cycle. The stimulus draws page numbers from a small pool and process identifiers from three values, so overwrites, evictions and cross-process near-misses happen often. It also freely combines lookup, fill and flush in the same cycle, and every such mix stays within the one-fill-per-cycle interface.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  localparam int PERM_W    = 3;
  localparam int PERM_RD   = 0;
  localparam int PERM_WR   = 1;
  localparam int PERM_EXEC = 2;

endpackage

// File: rtl/xlat_perm_check.sv
module xlat_perm_check
  import xlat_pkg::*;
(
  input  logic [1:0]        kind,
  input  logic [PERM_W-1:0] perm,
  output logic              allowed
);

  acc_kind_e k;

  always_comb begin
    k = acc_kind_e'(kind);
    unique case (k)
      ACC_READ:  allowed = perm[PERM_RD];
      ACC_WRITE: allowed = perm[PERM_WR];
      ACC_EXEC:  allowed = perm[PERM_EXEC];
      default:   allowed = 1'b0;
    endcase
  end

endmodule

// File: rtl/xlat_entry_array.sv
module xlat_entry_array
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PID_W   = 8,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [PID_W-1:0]   wr_pid,
  input  logic [PFN_W-1:0]   wr_pfn,
  input  logic [PERM_W-1:0]  wr_perm,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [PID_W-1:0]   lk_pid,
  output logic [ENTRIES-1:0] lk_match,
  output logic [ENTRIES-1:0] fill_match,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [PFN_W-1:0]   lk_pfn,
  output logic [PERM_W-1:0]  lk_perm
);

  logic [ENTRIES-1:0] e_val;
  logic [VPN_W-1:0]   e_vpn  [ENTRIES];
  logic [PID_W-1:0]   e_pid  [ENTRIES];
  logic [PFN_W-1:0]   e_pfn  [ENTRIES];
  logic [PERM_W-1:0]  e_perm [ENTRIES];

  // valid bits: the only state that reset and flush touch
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      e_val <= '0;
    end else if (wr_en) begin
      e_val[wr_idx] <= 1'b1;
    end
  end

  // payload fields: plain write-only storage, no reset
  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      e_vpn[wr_idx]  <= wr_vpn;
      e_pid[wr_idx]  <= wr_pid;
      e_pfn[wr_idx]  <= wr_pfn;
      e_perm[wr_idx] <= wr_perm;
    end
  end

  // parallel comparators, one pair per slot
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g]   = e_val[g] && (e_vpn[g] == lk_vpn) && (e_pid[g] == lk_pid);
    assign fill_match[g] = e_val[g] && (e_vpn[g] == wr_vpn) && (e_pid[g] == wr_pid);
  end

  assign valid_vec = e_val;

  // AND-OR read mux driven by the one-hot match vector
  always_comb begin
    lk_pfn  = '0;
    lk_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        lk_pfn  = lk_pfn  | e_pfn[i];
        lk_perm = lk_perm | e_perm[i];
      end
    end
  end

  // R7: overwrite-on-refill keeps at most one slot per page/process pair
  p_single_match_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match));

  // R5: a flush leaves no valid slot behind
  p_flush_clears_r5: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_vec == '0));

endmodule

// File: rtl/xlat_victim_sel.sv
module xlat_victim_sel #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fill_go,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] fill_match,
  output logic [IDX_W-1:0]   victim
);

  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] same_idx;
  logic             free_found;
  logic             same_found;
  logic             use_rr;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    same_found = 1'b0;
    same_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
      if (fill_match[i]) begin
        same_found = 1'b1;
        same_idx   = IDX_W'(i);
      end
    end
  end

  assign use_rr = !same_found && !free_found;

  always_comb begin
    if (same_found)      victim = same_idx;
    else if (free_found) victim = free_idx;
    else                 victim = rr_ptr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_ptr <= '0;
    end else if (fill_go && use_rr) begin
      rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end

  // R8: a fresh fill never lands on an occupied slot while an empty one exists
  p_victim_free_r8: assert property (@(posedge clk) disable iff (rst)
    (fill_go && (fill_match == '0) && !(&valid_vec)) |-> !valid_vec[victim]);

  // R7: a refill of a present pair lands on that pair's slot
  p_victim_same_r7: assert property (@(posedge clk) disable iff (rst)
    (fill_go && (fill_match != '0)) |-> fill_match[victim]);

endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xlat_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PFN_W   = 20,
  parameter int PID_W   = 8,
  parameter int ENTRIES = 16,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PA_W   = PFN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [PID_W-1:0]  lk_pid,
  input  logic [1:0]        lk_kind,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PID_W-1:0]  fill_pid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              flush,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_fault,
  output logic [PA_W-1:0]   rsp_paddr
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] fill_match;
  logic [ENTRIES-1:0] valid_vec;
  logic [PFN_W-1:0]   sel_pfn;
  logic [PERM_W-1:0]  sel_perm;
  logic [IDX_W-1:0]   wr_idx;
  logic               wr_en;
  logic               allowed;
  logic               hit_any;
  logic               good;

  // flush has priority over fill
  assign wr_en = fill_valid && !flush;

  xlat_entry_array #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PID_W   (PID_W),
    .PFN_W   (PFN_W)
  ) u_array (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_vpn     (fill_vpn),
    .wr_pid     (fill_pid),
    .wr_pfn     (fill_pfn),
    .wr_perm    (fill_perm),
    .lk_vpn     (lk_vaddr[VA_W-1:OFF_W]),
    .lk_pid     (lk_pid),
    .lk_match   (lk_match),
    .fill_match (fill_match),
    .valid_vec  (valid_vec),
    .lk_pfn     (sel_pfn),
    .lk_perm    (sel_perm)
  );

  xlat_victim_sel #(
    .ENTRIES (ENTRIES)
  ) u_victim (
    .clk        (clk),
    .rst        (rst),
    .fill_go    (wr_en),
    .valid_vec  (valid_vec),
    .fill_match (fill_match),
    .victim     (wr_idx)
  );

  xlat_perm_check u_check (
    .kind    (lk_kind),
    .perm    (sel_perm),
    .allowed (allowed)
  );

  // a lookup coinciding with a flush is treated as a miss
  assign hit_any = (|lk_match) && !flush;
  assign good    = lk_valid && hit_any && allowed;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= good;
      rsp_miss  <= lk_valid && !hit_any;
      rsp_fault <= lk_valid && hit_any && !allowed;
      rsp_paddr <= good ? {sel_pfn, lk_vaddr[OFF_W-1:0]} : '0;
    end
  end

  // R6: exactly one outcome per response
  p_one_outcome_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1));

  // R6: quiet when no lookup was made
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));

  // R1: offset bits travel through unchanged
  p_offset_pass_r1: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

  // R5: a lookup in a flush cycle reports a miss
  p_flush_miss_r5: assert property (@(posedge clk) disable iff (rst)
    (flush && lk_valid) |=> rsp_miss);

  // R4: no address escapes on a fault or miss
  p_no_addr_on_reject_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_fault || rsp_miss) |-> (rsp_paddr == '0));

endmodule

// File: tb/xlat_buffer_tb_top.sv
`timescale 1ns/1ps
module xlat_buffer_tb_top;

  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_pid = '0;
  logic [1:0]  lk_kind = '0;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [7:0]  fill_pid = '0;
  logic [19:0] fill_pfn = '0;
  logic [2:0]  fill_perm = '0;
  logic        flush = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [31:0] rsp_paddr;

  int checks = 0;
  int failures = 0;

  // reference model state
  bit         m_val  [N];
  bit [19:0]  m_vpn  [N];
  bit [7:0]   m_pid  [N];
  bit [19:0]  m_pfn  [N];
  bit [2:0]   m_perm [N];
  int         m_rr = 0;

  always #2.5 clk = ~clk;

  xlat_buffer dut_i (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid), .lk_kind(lk_kind),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pid(fill_pid),
    .fill_pfn(fill_pfn), .fill_perm(fill_perm), .flush(flush),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
  );

  function automatic bit kind_ok(input bit [1:0] k, input bit [2:0] p);
    case (k)
      2'b00:   return p[0];
      2'b01:   return p[1];
      2'b10:   return p[2];
      default: return 1'b0;
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_val[i] = 1'b0;
    m_rr = 0;
  endtask

  task automatic model_fill(input bit [19:0] vpn, input bit [7:0] pid,
                            input bit [19:0] pfn, input bit [2:0] perm);
    int slot = -1;
    for (int i = 0; i < N; i++)
      if (slot < 0 && m_val[i] && m_vpn[i] == vpn && m_pid[i] == pid) slot = i;
    if (slot < 0)
      for (int i = 0; i < N; i++)
        if (slot < 0 && !m_val[i]) slot = i;
    if (slot < 0) begin
      slot = m_rr;
      m_rr = (m_rr + 1) % N;
    end
    m_val[slot] = 1'b1; m_vpn[slot] = vpn; m_pid[slot] = pid;
    m_pfn[slot] = pfn;  m_perm[slot] = perm;
  endtask

  // one cycle: drive at a negedge, check the response at the next negedge
  task automatic step(input bit lk, input bit [31:0] va, input bit [7:0] pid,
                      input bit [1:0] kind, input bit fl, input bit [19:0] fvpn,
                      input bit [7:0] fpid, input bit [19:0] fpfn, input bit [2:0] fperm,
                      input bit fsh, input string tag);
    bit e_v = lk, e_h = 0, e_m = 0, e_f = 0;
    bit [31:0] e_pa = '0;
    if (lk) begin
      int s = -1;
      if (!fsh)
        for (int i = 0; i < N; i++)
          if (m_val[i] && m_vpn[i] == va[31:12] && m_pid[i] == pid) s = i;
      if (s < 0) e_m = 1;
      else if (kind_ok(kind, m_perm[s])) begin e_h = 1; e_pa = {m_pfn[s], va[11:0]}; end
      else e_f = 1;
    end
    lk_valid = lk; lk_vaddr = va; lk_pid = pid; lk_kind = kind;
    fill_valid = fl; fill_vpn = fvpn; fill_pid = fpid; fill_pfn = fpfn; fill_perm = fperm;
    flush = fsh;
    if (fsh) model_reset_vals();
    else if (fl) model_fill(fvpn, fpid, fpfn, fperm);
    @(negedge clk);
    checks++;
    if (rsp_valid !== e_v || rsp_hit !== e_h || rsp_miss !== e_m ||
        rsp_fault !== e_f || rsp_paddr !== e_pa) begin
      failures++;
      $display("FAIL %s: got v=%0b h=%0b m=%0b f=%0b pa=%h expected v=%0b h=%0b m=%0b f=%0b pa=%h",
               tag, rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr,
               e_v, e_h, e_m, e_f, e_pa);
    end
    lk_valid = 0; fill_valid = 0; flush = 0;
  endtask

  // a flush clears valid bits only; the pointer is kept
  task automatic model_reset_vals();
    for (int i = 0; i < N; i++) m_val[i] = 1'b0;
  endtask

  task automatic look(input bit [31:0] va, input bit [7:0] pid, input bit [1:0] k,
                      input string tag);
    step(1, va, pid, k, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic fill(input bit [19:0] vpn, input bit [7:0] pid, input bit [19:0] pfn,
                      input bit [2:0] perm, input string tag);
    step(0, 0, 0, 0, 1, vpn, pid, pfn, perm, 0, tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R11: outputs quiet after reset, every lookup misses
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 idle after reset");
    look(32'h0001_4303, 8'd3, 2'b00, "R11 miss after reset");
    // R10 / R1: worked example
    fill(20'h00014, 8'd3, 20'h00002, 3'b011, "R6 idle during fill");
    look(32'h0001_4303, 8'd3, 2'b00, "R10 example translation");
    look(32'h0001_4ABC, 8'd3, 2'b01, "R1 offset pass-through on write");
    // R2: other process, same page
    look(32'h0001_4303, 8'd4, 2'b00, "R2 pid mismatch misses");
    // R3: unmapped page
    look(32'h0001_5000, 8'd3, 2'b00, "R3 unmapped page misses");
    // R4: rights
    look(32'h0001_4010, 8'd3, 2'b10, "R4 execute without right faults");
    look(32'h0001_4010, 8'd3, 2'b11, "R4 reserved kind faults");
    // R7: overwrite in place
    fill(20'h00014, 8'd3, 20'h00007, 3'b111, "R7 overwrite fill");
    look(32'h0001_4303, 8'd3, 2'b10, "R7 overwritten frame and rights");
    // R8: fill slots 1..15, then round robin evicts slot 0 then slot 1
    for (int i = 0; i < 15; i++)
      fill(20'h00100 + 20'(i), 8'd1, 20'h00500 + 20'(i), 3'b001, "R8 fill free slot");
    look(32'h0001_4303, 8'd3, 2'b00, "R7 no duplicate slot used");
    fill(20'h00200, 8'd1, 20'h00600, 3'b001, "R8 first eviction");
    look(32'h0001_4303, 8'd3, 2'b00, "R8 slot 0 evicted");
    look(32'h0010_0000, 8'd1, 2'b00, "R8 slot 1 kept");
    fill(20'h00201, 8'd1, 20'h00601, 3'b001, "R8 second eviction");
    look(32'h0010_0000, 8'd1, 2'b00, "R8 slot 1 evicted");
    look(32'h0010_1000, 8'd1, 2'b00, "R8 slot 2 kept");
    // R9: lookup coinciding with fill sees old contents
    step(1, 32'h0030_0123, 8'd2, 2'b00, 1, 20'h00300, 8'd2, 20'h00AAA, 3'b001, 0,
         "R9 lookup during fill misses");
    look(32'h0030_0123, 8'd2, 2'b00, "R9 fill visible next cycle");
    // R5: flush with lookup in the same cycle
    step(1, 32'h0030_0123, 8'd2, 2'b00, 0, 0, 0, 0, 0, 1, "R5 lookup during flush misses");
    look(32'h0020_0000, 8'd1, 2'b00, "R5 mapping gone after flush");
    // R9: flush beats fill
    step(0, 0, 0, 0, 1, 20'h00400, 8'd5, 20'h00BBB, 3'b111, 1, "R9 flush with fill");
    look(32'h0040_0000, 8'd5, 2'b00, "R9 fill dropped by flush");
    // random mix
    void'($urandom(32'd12345));
    for (int n = 0; n < 600; n++) begin
      bit [19:0] vpn = 20'h00080 + 20'($urandom_range(0, 23));
      bit [19:0] fvpn = 20'h00080 + 20'($urandom_range(0, 23));
      bit [7:0]  pid = 8'($urandom_range(0, 2));
      bit [7:0]  fpid = 8'($urandom_range(0, 2));
      bit        lk = ($urandom_range(0, 99) < 65);
      bit        fl = ($urandom_range(0, 99) < 40);
      bit        fs = ($urandom_range(0, 99) < 3);
      step(lk, {vpn, 12'($urandom)}, pid, 2'($urandom), fl, fvpn, fpid,
           20'($urandom), 3'($urandom), fs, "random R2 R3 R4 R6 R7 R8");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule